// File: doc/BRIEF.md
# Dual-Mode Bundle Instruction Pointer

This block holds the address of the instruction the processor is currently executing. It supports two instruction-set modes. In bundle mode, instructions are grouped into 16-byte bundles that sit on 16-byte boundaries. The pointer therefore steps one whole bundle at a time, and its four lowest bits always read as zero. In byte mode, instructions may start at any byte. The pointer then carries a 32-bit linear address, zero-extended to 64 bits, and keeps its low bits exactly as computed.

The pointer has no write port. It moves in only two ways: it advances after an instruction retires, or it loads a target when a branch is taken. Its current value is visible at all times on a read port.

The mode select is sampled with the strobes. When the mode changes and no strobe is present, the stored pointer is refolded to the new mode's rules at the next clock edge. Instruction decoding, fetch and the handshake that switches modes belong to neighbouring blocks.

Top module: `instr_ptr_unit`

## Requirements
- R1: While reset is asserted and right after it, the read port shows the reset vector parameter with its four low bits cleared, and the block is in bundle mode (default vector 0x8000_0000_0000_100C reads as 0x8000_0000_0000_1000).
- R2: In bundle mode, an advance strobe with no branch adds exactly 16 to the pointer at the next clock edge.
- R3: In bundle mode, a taken branch loads the target with its four low bits forced to zero, and the read port's low four bits never read non-zero in this mode.
- R4: In byte mode, an advance strobe with no branch adds the supplied length (1 to 15) to the pointer and keeps the low four bits of the sum.
- R5: In byte mode, a taken branch loads the low 32 bits of the target, and bits 63:32 of the read port are always zero in this mode.
- R6: In byte mode, an advance that carries past 0xFFFF_FFFF wraps modulo 2^32.
- R7: When a branch and an advance arrive in the same cycle, the branch target is loaded and the advance is discarded, in either mode.
- R8: With no strobe and an unchanged mode, the pointer holds its value.
- R9: A mode change with no strobe refolds the stored pointer at the next edge: bundle mode clears bits 3:0, byte mode clears bits 63:32.
- R10: In bundle mode the length input has no effect; the step is 16 whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_mode | input | 1 | 1 selects byte-aligned 32-bit mode, 0 selects bundle mode |
| step_en | input | 1 | Advance past the current instruction |
| step_len | input | 4 | Instruction length in bytes for byte mode (1 to 15) |
| jump_en | input | 1 | Taken-branch strobe |
| jump_addr | input | 64 | Branch target |
| ip_rd | output | 64 | Current pointer value (move-from-IP read port) |

## Verification
The hardest condition to reach is a mode change that arrives with neither strobe active. In that case the stored value must be refolded without any arithmetic taking place.

The stimulus sets this up in two steps. First it loads a bundle-mode branch target whose upper half is non-zero and switches to byte mode with no strobe. It then later parks the pointer on an address whose low nibble is non-zero and switches back to bundle mode, again with no strobe. This exposes both the upper-word clear and the low-nibble clear.

A further branch to just below 2^32, followed by an advance, drives the 32-bit wrap.

// File: rtl/ip_pkg.sv
package ip_pkg;
  typedef enum logic {
    IPM_BUNDLE = 1'b0,
    IPM_BYTE   = 1'b1
  } ip_mode_e;

  typedef enum logic [1:0] {
    IPS_HOLD = 2'd0,
    IPS_STEP = 2'd1,
    IPS_JUMP = 2'd2
  } ip_src_e;
endpackage

// File: rtl/ip_step_gen.sv
module ip_step_gen
  import ip_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int LEN_W        = 4,
  parameter int BUNDLE_BYTES = 16
) (
  input  logic [ADDR_W-1:0] cur_ip,
  input  ip_mode_e          mode,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] seq_ip
);
  localparam logic [ADDR_W-1:0] BUNDLE_STEP = ADDR_W'(BUNDLE_BYTES);

  logic [ADDR_W-1:0] incr;

  always_comb begin
    if (mode == IPM_BYTE) incr = ADDR_W'(len);
    else                  incr = BUNDLE_STEP;
    seq_ip = cur_ip + incr;
  end
endmodule

// File: rtl/ip_mode_fold.sv
module ip_mode_fold
  import ip_pkg::*;
#(
  parameter int ADDR_W       = 64,
  parameter int LEG_W        = 32,
  parameter int BUNDLE_BYTES = 16
) (
  input  logic [ADDR_W-1:0] raw_ip,
  input  ip_mode_e          mode,
  output logic [ADDR_W-1:0] folded_ip
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(BUNDLE_BYTES - 1));

  logic [ADDR_W-1:0] byte_view;

  generate
    if (LEG_W < ADDR_W) begin : g_zext
      assign byte_view = {{(ADDR_W-LEG_W){1'b0}}, raw_ip[LEG_W-1:0]};
    end else begin : g_full
      assign byte_view = raw_ip;
    end
  endgenerate

  always_comb begin
    if (mode == IPM_BYTE) folded_ip = byte_view;
    else                  folded_ip = raw_ip & ALIGN_MASK;
  end
endmodule

// File: rtl/instr_ptr_unit.sv
module instr_ptr_unit
  import ip_pkg::*;
#(
  parameter int                 ADDR_W       = 64,
  parameter int                 LEG_W        = 32,
  parameter int                 LEN_W        = 4,
  parameter int                 BUNDLE_BYTES = 16,
  parameter logic [ADDR_W-1:0]  RESET_VEC    = 64'h8000_0000_0000_100C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              step_en,
  input  logic [LEN_W-1:0]  step_len,
  input  logic              jump_en,
  input  logic [ADDR_W-1:0] jump_addr,
  output logic [ADDR_W-1:0] ip_rd
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(BUNDLE_BYTES - 1));
  localparam logic [ADDR_W-1:0] RESET_IP   = RESET_VEC & ALIGN_MASK;

  ip_mode_e          mode_d, mode_q;
  ip_src_e           src;
  logic [ADDR_W-1:0] ip_q, ip_d, seq_ip, raw_ip;
  logic              ip_en;

  assign mode_d = ip_mode_e'(byte_mode);

  ip_step_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BUNDLE_BYTES(BUNDLE_BYTES)
  ) u_step (
    .cur_ip(ip_q), .mode(mode_d), .len(step_len), .seq_ip(seq_ip)
  );

  // Branch wins over sequential advance
  always_comb begin
    if (jump_en)      src = IPS_JUMP;
    else if (step_en) src = IPS_STEP;
    else              src = IPS_HOLD;
    case (src)
      IPS_JUMP: raw_ip = jump_addr;
      IPS_STEP: raw_ip = seq_ip;
      default:  raw_ip = ip_q;
    endcase
    ip_en = (src != IPS_HOLD) || (mode_d != mode_q);
  end

  ip_mode_fold #(
    .ADDR_W(ADDR_W), .LEG_W(LEG_W), .BUNDLE_BYTES(BUNDLE_BYTES)
  ) u_fold (
    .raw_ip(raw_ip), .mode(mode_d), .folded_ip(ip_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q   <= RESET_IP;
      mode_q <= IPM_BUNDLE;
    end else if (ip_en) begin
      ip_q   <= ip_d;
      mode_q <= mode_d;
    end
  end

  assign ip_rd = ip_q;

  assert_bundle_low_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == IPM_BUNDLE) |-> (ip_rd[3:0] == 4'h0));

  assert_byte_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == IPM_BYTE) |-> (ip_rd[ADDR_W-1:LEG_W] == '0));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_en && !step_en && (mode_d == mode_q)) |=> $stable(ip_rd));

  assert_bundle_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!jump_en && step_en && !byte_mode && (mode_q == IPM_BUNDLE))
      |=> (ip_rd == $past(ip_rd) + ADDR_W'(BUNDLE_BYTES)));

  assert_jump_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_en && !byte_mode) |=> (ip_rd == ($past(jump_addr) & ALIGN_MASK)));
endmodule

// File: tb/instr_ptr_unit_test.sv
`timescale 1ns/1ps
module instr_ptr_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_mode;
  logic        step_en;
  logic [3:0]  step_len;
  logic        jump_en;
  logic [63:0] jump_addr;
  logic [63:0] ip_rd;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  instr_ptr_unit uut (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .step_en(step_en),
    .step_len(step_len), .jump_en(jump_en), .jump_addr(jump_addr), .ip_rd(ip_rd)
  );

  task automatic check(input string req, input logic [63:0] exp);
    checks++;
    if (ip_rd !== exp) begin
      errors++;
      $display("FAIL %s: ip_rd=%h expected=%h", req, ip_rd, exp);
    end
  endtask

  // Drive one cycle at a negedge, return at the following negedge
  task automatic cyc(input logic md, input logic jmp, input logic [63:0] tgt,
                     input logic stp, input logic [3:0] len);
    byte_mode = md; jump_en = jmp; jump_addr = tgt; step_en = stp; step_len = len;
    @(posedge clk);
    @(negedge clk);
    jump_en = 1'b0; step_en = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; byte_mode = 0; step_en = 0; step_len = 0; jump_en = 0; jump_addr = '0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 64'h8000_0000_0000_1000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'h8000_0000_0000_1000);
  endtask

  task automatic t_bundle_step;
    logic [63:0] e = 64'h8000_0000_0000_1000;
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, '0, 1, 4'(7 + 4 * i));
      e = e + 64'd16;
      check("R2/R10 bundle step", e);
    end
  endtask

  task automatic t_bundle_jump;
    cyc(0, 1, 64'h1234_5678_9ABC_DEF5, 0, 0);
    check("R3 bundle jump align", 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 4'hF);
      check("R8 hold", 64'h1234_5678_9ABC_DEF0);
    end
  endtask

  task automatic t_bundle_priority;
    cyc(0, 1, 64'h0000_0000_0000_0040, 1, 4'h3);
    check("R7 bundle jump beats step", 64'h40);
  endtask

  task automatic t_to_byte;
    cyc(0, 1, 64'hABCD_0000_0000_1230, 0, 0);
    check("R3 setup", 64'hABCD_0000_0000_1230);
    cyc(1, 0, '0, 0, 0);
    check("R9 switch to byte clears upper", 64'h1230);
  endtask

  task automatic t_byte_step;
    cyc(1, 0, '0, 1, 4'd3);  check("R4 byte step 3", 64'h1233);
    cyc(1, 0, '0, 1, 4'd15); check("R4 byte step 15", 64'h1242);
    cyc(1, 0, '0, 1, 4'd1);  check("R4 byte step 1", 64'h1243);
  endtask

  task automatic t_byte_jump;
    cyc(1, 1, 64'hFFFF_0000_8765_4327, 0, 0);
    check("R5 byte jump zext", 64'h8765_4327);
  endtask

  task automatic t_wrap;
    cyc(1, 1, 64'h0000_0000_FFFF_FFFE, 0, 0);
    check("R6 setup", 64'hFFFF_FFFE);
    cyc(1, 0, '0, 1, 4'd5);
    check("R6 wrap", 64'h3);
  endtask

  task automatic t_byte_priority;
    cyc(1, 1, 64'h55, 1, 4'd9);
    check("R7 byte jump beats step", 64'h55);
  endtask

  task automatic t_to_bundle;
    cyc(0, 0, '0, 0, 0);
    check("R9 switch to bundle clears nibble", 64'h50);
    cyc(0, 0, '0, 1, 4'd2);
    check("R2 step after switch", 64'h60);
  endtask

  initial begin
    t_reset();
    t_bundle_step();
    t_bundle_jump();
    t_hold();
    t_bundle_priority();
    t_to_byte();
    t_byte_step();
    t_byte_jump();
    t_wrap();
    t_byte_priority();
    t_to_bundle();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule